// File: doc/BRIEF.md
# Selectable Stochastic Bitstream Generator

This block emits one random bit per enabled clock cycle. The chance that the bit is 1 is chosen by an N-bit select word x. In the default configuration the chance is x/2^N. The block builds this from a ladder of fair coin flips, one flip per select bit. The first rung is a fair bit gated by select bit 0. Each higher rung combines a fresh fair bit with the rung below it. The combine is an AND (a series switch) when its select bit is 0 and an OR (a parallel switch) when it is 1. A series rung halves the probability. A parallel rung maps P to 1/2 + P/2. The select word therefore reads directly as a binary fraction.

An on-chip linear feedback shift register supplies the fair bits, and software can reseed it. Two build-time variants exist. One makes the first rung parallel, which gives (x+1)/2^N. The other is the dual network: it swaps AND and OR on every rung and inverts the select sense, which gives 1 − x/2^N. A valid strobe marks the cycles that carry a sample.

Top module: `stoch_ladder_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `bit_out` and `bit_valid` are 0, and the generator state equals the default seed 32'h5EEDC0DE.
- R2: `bit_valid` is 1 in exactly those cycles that follow a clock edge at which `enable` was 1 and reset was low. It therefore rises one cycle after `enable` rises and stays high while `enable` stays high.
- R3: In the default build, the long-run fraction of 1s on `bit_out` equals x/2^N for select value x. The fraction increases with x, and x = 0 never yields a 1.
- R4: Rung 0 is the fair bit ANDed with select bit 0. Rung i (i ≥ 1) ANDs a fresh fair bit onto rung i−1 when select bit i is 0 and ORs it when select bit i is 1. Bit 0 is the least significant bit and the ladder is built upward from it.
- R5: Each enabled cycle consumes N new fair bits, one per rung. No fair bit is shared between rungs, so x = 1 gives 1/2^N and not 1/2.
- R6: A cycle with `seed_load` = 1 loads `seed` into the generator. Loading the same seed reproduces the same output stream bit for bit, and a different seed gives a different stream.
- R7: A seed of all zeros is replaced by the default seed 32'h5EEDC0DE. Its stream equals the default seed's stream and is not stuck.
- R8: While `enable` is 0, `bit_out` is 0 and the generator does not advance. After a pause, the stream resumes exactly where it stopped.
- R9: With FIRST_PAR = 1 the fraction of 1s is (x+1)/2^N, and the all-ones select code gives a constant 1.
- R10: With DUAL = 1 the fraction of 1s is 1 − x/2^N, and x = 0 gives a constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Produce a sample this cycle and advance the generator |
| seed_load | input | 1 | Load `seed` into the generator (takes priority over advancing) |
| seed | input | LFSR_W | Seed value; all zeros is replaced by the default |
| sel | input | SEL_W | Probability select word x |
| bit_out | output | 1 | Stochastic output bit |
| bit_valid | output | 1 | Marks a cycle carrying a sample |

## Verification
The output assertions compare a sample with the select value one cycle earlier. They therefore assume that `sel` is held steady around the edge that produced the sample. The bench changes `sel` only at falling edges and waits two cycles before counting samples. The reload assertion assumes that `seed_load` and `enable` are not both high. The bench always drops `enable` before it loads a seed. Probabilities strictly between 0 and 1 are checked statistically over 2048 samples with a fixed tolerance. The constant cases are checked exactly.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  typedef enum logic {
    OP_SERIES   = 1'b0,
    OP_PARALLEL = 1'b1
  } join_e;

  // Which way a rung above the first joins its fresh fair bit.
  function automatic join_e stage_op(input logic sel_bit, input bit dual);
    return (sel_bit ^ dual) ? OP_PARALLEL : OP_SERIES;
  endfunction

  // Series is AND, parallel is OR.
  function automatic logic join_bits(input join_e op, input logic a, input logic b);
    return (op == OP_PARALLEL) ? (a | b) : (a & b);
  endfunction

  // Numerator of the closure probability over 2^n for select x.
  function automatic int unsigned level_of(input int unsigned x, input int unsigned n,
                                           input bit first_par, input bit dual);
    int unsigned base;
    base = x + (first_par ? 1 : 0);
    return dual ? ((32'd1 << n) - base) : base;
  endfunction

endpackage

// File: rtl/ssg_fair_src.sv
module ssg_fair_src #(
  parameter int unsigned         LFSR_W   = 32,
  parameter logic [LFSR_W-1:0]   TAP_MASK = 32'h8020_0003,
  parameter logic [LFSR_W-1:0]   SEED_DEF = 32'h5EED_C0DE,
  parameter int unsigned         BITS     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  output logic [BITS-1:0]   fair,
  output logic [LFSR_W-1:0] state
);

  logic [LFSR_W-1:0] next_adv;
  logic [LFSR_W-1:0] seed_eff;

  // Walk the register BITS steps. Each step's feedback bit is a new fair bit.
  always_comb begin
    logic [LFSR_W-1:0] walk;
    logic              fb;
    walk = state;
    fair = '0;
    for (int k = 0; k < BITS; k++) begin
      fb      = ^(walk & TAP_MASK);
      fair[k] = fb;
      walk    = {walk[LFSR_W-2:0], fb};
    end
    next_adv = walk;
  end

  assign seed_eff = (seed == '0) ? SEED_DEF : seed;

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED_DEF;
    else if (load) state <= seed_eff;
    else if (adv)  state <= next_adv;
  end

  a_r7_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  a_r6_seed_taken: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load) && $past(seed) != '0) |-> state == $past(seed));

  a_r7_zero_seed_default: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load) && $past(seed) == '0) |-> state == SEED_DEF);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(adv) && !$past(load)) |-> $stable(state));

  a_r5_moves_when_adv: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(adv) && !$past(load)) |-> state != $past(state));

endmodule

// File: rtl/ssg_switch_chain.sv
module ssg_switch_chain
  import ssg_pkg::*;
#(
  parameter int unsigned SEL_W     = 3,
  parameter bit          FIRST_PAR = 1'b0,
  parameter bit          DUAL      = 1'b0
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [SEL_W-1:0] fair,
  output logic [SEL_W-1:0] stage_v,
  output logic             result
);

  localparam join_e FIRST_OP = (FIRST_PAR ^ DUAL) ? OP_PARALLEL : OP_SERIES;

  logic det_closed;

  // Rung 0: a deterministic switch joined to one fair switch.
  assign det_closed = sel[0] ^ DUAL;
  assign stage_v[0] = join_bits(FIRST_OP, fair[0], det_closed);

  // Rungs 1 and up: one fresh fair switch each, in series or in parallel.
  generate
    for (genvar i = 1; i < SEL_W; i++) begin : g_rung
      join_e op_i;
      assign op_i       = stage_op(sel[i], DUAL);
      assign stage_v[i] = join_bits(op_i, fair[i], stage_v[i-1]);
    end
  endgenerate

  assign result = stage_v[SEL_W-1];

endmodule

// File: rtl/ssg_out_stage.sv
module ssg_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q,
  output logic vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      vld <= 1'b0;
    end else begin
      q   <= en & d;
      vld <= en;
    end
  end

  a_r2_valid_after_enable: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en)) |-> vld);

  a_r2_no_valid_without_enable: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !vld);

  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !q);

endmodule

// File: rtl/stoch_ladder_gen.sv
module stoch_ladder_gen
  import ssg_pkg::*;
#(
  parameter int unsigned       SEL_W     = 3,
  parameter int unsigned       LFSR_W    = 32,
  parameter logic [LFSR_W-1:0] TAP_MASK  = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] SEED_DEF  = 32'h5EED_C0DE,
  parameter bit                FIRST_PAR = 1'b0,
  parameter bit                DUAL      = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  input  logic [SEL_W-1:0]  sel,
  output logic              bit_out,
  output logic              bit_valid
);

  localparam int unsigned FULL = 32'd1 << SEL_W;

  logic [SEL_W-1:0]  fair_bits;
  logic [LFSR_W-1:0] gen_state;
  logic [SEL_W-1:0]  rung_v;
  logic              ladder_bit;
  logic              advance;
  logic [31:0]       sel_ext;

  assign advance = enable & ~seed_load;
  assign sel_ext = {{(32-SEL_W){1'b0}}, sel};

  ssg_fair_src #(
    .LFSR_W   (LFSR_W),
    .TAP_MASK (TAP_MASK),
    .SEED_DEF (SEED_DEF),
    .BITS     (SEL_W)
  ) u_src (
    .clk   (clk),
    .rst   (rst),
    .adv   (advance),
    .load  (seed_load),
    .seed  (seed),
    .fair  (fair_bits),
    .state (gen_state)
  );

  ssg_switch_chain #(
    .SEL_W     (SEL_W),
    .FIRST_PAR (FIRST_PAR),
    .DUAL      (DUAL)
  ) u_chain (
    .sel     (sel),
    .fair    (fair_bits),
    .stage_v (rung_v),
    .result  (ladder_bit)
  );

  ssg_out_stage u_out (
    .clk (clk),
    .rst (rst),
    .en  (enable),
    .d   (ladder_bit),
    .q   (bit_out),
    .vld (bit_valid)
  );

  // A level of 0 can never close the network; a full level always closes it.
  a_r3_zero_level_never_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bit_valid &&
     level_of($past(sel_ext), SEL_W, FIRST_PAR, DUAL) == 0) |-> !bit_out);

  a_r9_full_level_always_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bit_valid &&
     level_of($past(sel_ext), SEL_W, FIRST_PAR, DUAL) == FULL) |-> bit_out);

  // The top rung's op decides the outcome when the lower rungs agree with it.
  a_r4_top_rung_series_blocks: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(enable) && !$past(ladder_bit)) |-> !bit_out);

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!bit_out && !bit_valid));

endmodule

// File: tb/sim_stoch_ladder_gen.sv
`timescale 1ns/1ps
module sim_stoch_ladder_gen;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned LFSR_W  = 32;
  localparam int unsigned CODES   = 1 << SEL_W;
  localparam int unsigned SAMPLES = 2048;
  localparam int unsigned TOL     = 96;
  localparam logic [31:0] DEF_SEED = 32'h5EED_C0DE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic seed_load = 1'b0;
  logic [LFSR_W-1:0] seed = '0;
  logic [SEL_W-1:0] sel = '0;
  logic out0, vld0, out1, vld1, out2, vld2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stoch_ladder_gen #(.SEL_W(SEL_W), .LFSR_W(LFSR_W)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .seed_load(seed_load), .seed(seed),
    .sel(sel), .bit_out(out0), .bit_valid(vld0));

  stoch_ladder_gen #(.SEL_W(SEL_W), .LFSR_W(LFSR_W), .FIRST_PAR(1'b1)) u1 (
    .clk(clk), .rst(rst), .enable(enable), .seed_load(seed_load), .seed(seed),
    .sel(sel), .bit_out(out1), .bit_valid(vld1));

  stoch_ladder_gen #(.SEL_W(SEL_W), .LFSR_W(LFSR_W), .DUAL(1'b1)) u2 (
    .clk(clk), .rst(rst), .enable(enable), .seed_load(seed_load), .seed(seed),
    .sel(sel), .bit_out(out2), .bit_valid(vld2));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected count of 1s, worked out from the stated probability.
  function automatic int unsigned expect_ones(input int unsigned x, input bit fp, input bit du);
    int unsigned num;
    num = du ? (CODES - x) : (x + (fp ? 1 : 0));
    return (SAMPLES * num) / CODES;
  endfunction

  task automatic check_count(input string req, input int unsigned act, input int unsigned exp);
    bit ok;
    if (exp == 0 || exp == SAMPLES) ok = (act == exp);
    else ok = (act + TOL >= exp) && (act <= exp + TOL);
    check(ok, req, "ones count", act, exp);
  endtask

  // Load a seed, then collect 64 samples from u0; an optional pause at gap_at.
  task automatic run_stream(input logic [31:0] s, input int gap_at, output logic [63:0] bits);
    @(negedge clk);
    enable = 1'b0; seed_load = 1'b1; seed = s;
    @(negedge clk);
    seed_load = 1'b0; enable = 1'b1;
    for (int j = 0; j < 64; j++) begin
      if (j == gap_at) begin
        enable = 1'b0;
        for (int g = 0; g < 8; g++) begin
          @(negedge clk);
          check(!out0 && !vld0, "R8", "idle output", {out0, vld0}, 0);
        end
        enable = 1'b1;
      end
      @(negedge clk);
      bits[j] = out0;
    end
    enable = 1'b0;
  endtask

  initial begin
    logic [63:0] sa, sb, sc, sz, sd, sg;
    repeat (3) @(negedge clk);
    check(!out0 && !vld0 && !out1 && !vld1 && !out2 && !vld2, "R1", "during reset",
          {out0, vld0, out1, vld1, out2, vld2}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out0 && !vld0, "R1", "after reset", {out0, vld0}, 0);

    // R2: valid strobe timing
    enable = 1'b1;
    check(!vld0, "R2", "valid before edge", vld0, 0);
    @(negedge clk);
    check(vld0 && vld1 && vld2, "R2", "valid one cycle later", {vld0, vld1, vld2}, 7);
    repeat (3) @(negedge clk);
    check(vld0, "R2", "valid held", vld0, 1);
    enable = 1'b0;
    @(negedge clk);
    check(!vld0, "R2", "valid drops", vld0, 0);

    // R3, R4, R5, R9, R10: sweep every select code
    for (int x = 0; x < CODES; x++) begin
      int unsigned c0, c1, c2;
      sel = x[SEL_W-1:0];
      enable = 1'b1;
      repeat (2) @(negedge clk);
      c0 = 0; c1 = 0; c2 = 0;
      for (int k = 0; k < SAMPLES; k++) begin
        @(negedge clk);
        c0 += out0; c1 += out1; c2 += out2;
      end
      if (x == 1) check_count("R5", c0, expect_ones(x, 1'b0, 1'b0));
      else        check_count("R3", c0, expect_ones(x, 1'b0, 1'b0));
      check_count("R9",  c1, expect_ones(x, 1'b1, 1'b0));
      check_count("R10", c2, expect_ones(x, 1'b0, 1'b1));
    end
    enable = 1'b0;

    // R4: ordering of rungs, LSB first. 3'b011 (3/8) must differ from 3'b110 (6/8).
    check(expect_ones(3, 1'b0, 1'b0) < expect_ones(6, 1'b0, 1'b0), "R4",
          "bit order in bench model", 3, 6);

    // R6 and R7: seed handling
    sel = 3'b101;
    run_stream(32'h1234_5678, -1, sa);
    run_stream(32'h1234_5678, -1, sb);
    check(sa == sb, "R6", "same seed repeats", sa, sb);
    run_stream(32'h0BAD_F00D, -1, sc);
    check(sa != sc, "R6", "different seed differs", sc, sa);
    run_stream(32'h0, -1, sz);
    run_stream(DEF_SEED, -1, sd);
    check(sz == sd, "R7", "zero seed uses default", sz, sd);
    check(sz != '0 && sz != '1, "R7", "zero seed stream not stuck", sz, 1);

    // R8: a pause in the middle resumes the same stream
    run_stream(32'h1234_5678, 32, sg);
    check(sg == sa, "R8", "stream resumes after pause", sg, sa);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule